// File: doc/BRIEF.md
# PHY Test-Port Register Slave

This block is the configuration register file that sits behind the slow test port of a receive PHY. Firmware drives the port by toggling individual pins. The pins are a test clock, a test enable, a test clear and an 8-bit data input. An 8-bit data output returns a value. The block brings all of these pins into its own clock domain through synchronizer chains and watches the synchronized test clock for edges. The test clock rests high when the port is idle.

A transaction has two phases on the one clock pin. In the first phase, firmware holds enable high and pulls the test clock low. The data input is then taken as the register address. In the second phase, firmware drops enable, places the data on the input and returns the clock high. The data is then stored at the address that was latched. The address is kept after a write, so several writes can go to one register without a new address phase.

The stored values drive the PHY's receive controls: one byte for the clock lane, one byte for each of four data lanes, and one byte for the settle-time counter. A mode byte at address 0x00 holds the PHY in a test mode while it is non-zero. Writing zero to that byte returns the PHY to normal operation.

Top module: `phy_tport_slave`

## Requirements
- R1: A falling edge of the synchronized test clock while enable is 1 loads the data input as the current address, visible on the data output three clock cycles after the pin edge.
- R2: A rising edge of the synchronized test clock while enable is 0 writes the data input into the register at the current address.
- R3: A rising edge while enable is 1, or a falling edge while enable is 0, changes neither the address nor any register.
- R4: The data output always shows the register at the current address; addresses without a register read as 0x00, and writes to them are dropped.
- R5: While the synchronized test clear is 1, every register and the address are held at zero; clear wins over a same-cycle edge.
- R6: The registers are decoded as follows, and each one drives its own output byte:
  - address 0x34 drives `hs_ctl_clk`;
  - addresses 0x44, 0x54, 0x84 and 0x94 drive lane bytes 0 to 3 of `hs_ctl_lane` (lane 0 is bits 7:0);
  - address 0x75 drives `settle_ctl`.
- R7: `test_mode` is 1 exactly when the register at 0x00 is non-zero; writing 0x00 to address 0x00 clears it.
- R8: After reset, every register, the address and the data output are zero, and the idle-high test clock produces no edge.
- R9: The address persists across writes, so consecutive data phases without an address phase all land in the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tp_clk | input | 1 | Test clock pin (asynchronous, idles high) |
| tp_en | input | 1 | Test enable pin: 1 selects the address phase |
| tp_clr | input | 1 | Test clear pin, level sensitive |
| tp_din | input | 8 | Test data input (address or data) |
| tp_dout | output | 8 | Contents of the register at the current address |
| test_mode | output | 1 | High while the mode register is non-zero |
| hs_ctl_clk | output | 8 | Clock-lane receive control byte |
| hs_ctl_lane | output | 32 | Data-lane receive control bytes, lane 0 in bits 7:0 |
| settle_ctl | output | 8 | Settle-time counter control byte |

## Verification
The assertions check these rules on every cycle:
- a load event makes the address follow the synchronized input one cycle later;
- a write event makes an implemented register readable on the next cycle;
- a misdirected edge leaves the address and the output unchanged;
- unimplemented addresses read as zero;
- clear forces everything to zero;
- rising and falling events never occur together.

Other behaviour can only be shown by the bench's pin-level scenarios:
- the three-cycle path from a pin edge to the output;
- the address mapping to each control output byte;
- the entry into and exit from test mode;
- the way the address persists across writes.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  localparam int DW    = 8;
  localparam int AW    = 8;
  localparam int NREG  = 7;
  localparam int NLANE = 4;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] data_t;

  // register slot indices; the lane slots are contiguous
  localparam int IDX_MODE   = 0;
  localparam int IDX_CLK    = 1;
  localparam int IDX_LANE0  = 2;
  localparam int IDX_SETTLE = IDX_LANE0 + NLANE;

  localparam addr_t REG_ADDR [NREG] = '{
    8'h00, 8'h34, 8'h44, 8'h54, 8'h84, 8'h94, 8'h75
  };

  function automatic logic is_impl(addr_t a);
    for (int i = 0; i < NREG; i++)
      if (REG_ADDR[i] == a) return 1'b1;
    return 1'b0;
  endfunction
endpackage

// File: rtl/tpr_sync.sv
module tpr_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tpr_edge_cmd.sv
module tpr_edge_cmd
  import tpr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tck_s,
  input  logic  en_s,
  input  logic  clr_s,
  input  addr_t din_s,
  output logic  rise_evt,
  output logic  fall_evt,
  output logic  ld_evt,
  output logic  wr_evt,
  output addr_t addr_q
);
  logic tck_d;

  // previous sample resets high to match the idle level of the test clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tck_d <= 1'b1;
    else        tck_d <= tck_s;
  end

  assign rise_evt = tck_s & ~tck_d;
  assign fall_evt = ~tck_s & tck_d;
  assign ld_evt   = fall_evt & en_s & ~clr_s;
  assign wr_evt   = rise_evt & ~en_s & ~clr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (clr_s)  addr_q <= '0;
    else if (ld_evt) addr_q <= din_s;
  end
endmodule

// File: rtl/tpr_regs.sv
module tpr_regs
  import tpr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  addr_t                addr,
  input  data_t                wdata,
  output data_t                rdata,
  output logic [NREG*DW-1:0]   regs_flat
);
  data_t r [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             r[g] <= '0;
      else if (clr)                           r[g] <= '0;
      else if (wr_en && addr == REG_ADDR[g])  r[g] <= wdata;
    end
    assign regs_flat[g*DW +: DW] = r[g];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (addr == REG_ADDR[i]) rdata = r[i];
  end
endmodule

// File: rtl/phy_tport_slave.sv
module phy_tport_slave
  import tpr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tp_clk,
  input  logic                tp_en,
  input  logic                tp_clr,
  input  logic [DW-1:0]       tp_din,
  output logic [DW-1:0]       tp_dout,
  output logic                test_mode,
  output logic [DW-1:0]       hs_ctl_clk,
  output logic [NLANE*DW-1:0] hs_ctl_lane,
  output logic [DW-1:0]       settle_ctl
);
  localparam int CW = 3;

  logic [CW-1:0]      ctl_s;
  logic               tck_s, en_s, clr_s;
  addr_t              din_s;
  logic               rise_evt, fall_evt, ld_evt, wr_evt;
  addr_t              addr_q;
  logic [NREG*DW-1:0] regs_flat;

  tpr_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d({tp_clr, tp_en, tp_clk}), .q(ctl_s)
  );
  tpr_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .d(tp_din), .q(din_s)
  );

  assign tck_s = ctl_s[0];
  assign en_s  = ctl_s[1];
  assign clr_s = ctl_s[2];

  tpr_edge_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .tck_s(tck_s), .en_s(en_s), .clr_s(clr_s),
    .din_s(din_s), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .ld_evt(ld_evt), .wr_evt(wr_evt), .addr_q(addr_q)
  );

  tpr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .clr(clr_s), .wr_en(wr_evt), .addr(addr_q),
    .wdata(din_s), .rdata(tp_dout), .regs_flat(regs_flat)
  );

  assign test_mode   = |regs_flat[IDX_MODE*DW +: DW];
  assign hs_ctl_clk  = regs_flat[IDX_CLK*DW +: DW];
  assign hs_ctl_lane = regs_flat[IDX_LANE0*DW +: NLANE*DW];
  assign settle_ctl  = regs_flat[IDX_SETTLE*DW +: DW];
endmodule

// File: rtl/phy_tport_slave_chk.sv
module phy_tport_slave_chk
  import tpr_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  rise_evt,
  input logic  fall_evt,
  input logic  ld_evt,
  input logic  wr_evt,
  input logic  en_s,
  input logic  clr_s,
  input addr_t din_s,
  input addr_t addr_q,
  input data_t tp_dout,
  input logic  test_mode
);
  // R1
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_evt |=> addr_q == $past(din_s));

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && is_impl(addr_q)) |=> tp_dout == $past(din_s));

  // R3
  wrong_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((rise_evt && en_s) || (fall_evt && !en_s)) && !clr_s)
      |=> ($stable(addr_q) && $stable(tp_dout)));

  // R4
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_impl(addr_q) |-> tp_dout == '0);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (addr_q == '0 && tp_dout == '0 && !test_mode));

  // R7
  mode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q == '0) |-> (test_mode == (tp_dout != '0)));

  // R8
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));
endmodule

bind phy_tport_slave phy_tport_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .ld_evt(ld_evt), .wr_evt(wr_evt), .en_s(en_s), .clr_s(clr_s),
  .din_s(din_s), .addr_q(addr_q), .tp_dout(tp_dout), .test_mode(test_mode)
);

// File: tb/phy_tport_slave_tb.sv
`timescale 1ns/1ps
module phy_tport_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tp_clk = 1'b1, tp_en = 1'b0, tp_clr = 1'b0;
  logic [7:0]  tp_din = 8'h00;
  logic [7:0]  tp_dout, hs_ctl_clk, settle_ctl;
  logic [31:0] hs_ctl_lane;
  logic        test_mode;

  int checks = 0, errors = 0;
  logic [7:0] model [256];
  logic [7:0] cur_addr = 8'h00;

  always #2.5 clk = ~clk;

  phy_tport_slave u_dut (
    .clk(clk), .rst_n(rst_n), .tp_clk(tp_clk), .tp_en(tp_en), .tp_clr(tp_clr),
    .tp_din(tp_din), .tp_dout(tp_dout), .test_mode(test_mode),
    .hs_ctl_clk(hs_ctl_clk), .hs_ctl_lane(hs_ctl_lane), .settle_ctl(settle_ctl)
  );

  function automatic logic has_reg(logic [7:0] a);
    case (a)
      8'h00, 8'h34, 8'h44, 8'h54, 8'h84, 8'h94, 8'h75: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    return has_reg(a) ? model[a] : 8'h00;
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    check(req, {24'h0, tp_dout}, {24'h0, exp_read(cur_addr)});
    check(req, {31'h0, test_mode}, {31'h0, model[8'h00] != 8'h00});
    check(req, {24'h0, hs_ctl_clk}, {24'h0, model[8'h34]});
    check(req, hs_ctl_lane, {model[8'h94], model[8'h84], model[8'h54], model[8'h44]});
    check(req, {24'h0, settle_ctl}, {24'h0, model[8'h75]});
  endtask

  // address phase: falling edge with enable high, then idle rise (still enabled)
  task automatic put_addr(logic [7:0] a);
    tp_din = a; tp_en = 1'b1; wait_cyc(4);
    tp_clk = 1'b0; wait_cyc(4);
    tp_clk = 1'b1; wait_cyc(4);
    cur_addr = a;
  endtask

  // data phase: falling edge with enable low (ignored), rising edge writes
  task automatic put_data(logic [7:0] d);
    tp_din = d; tp_en = 1'b0; wait_cyc(4);
    tp_clk = 1'b0; wait_cyc(4);
    tp_clk = 1'b1; wait_cyc(4);
    if (has_reg(cur_addr)) model[cur_addr] = d;
  endtask

  task automatic do_clear();
    tp_clr = 1'b1; wait_cyc(5);
    tp_clr = 1'b0; wait_cyc(4);
    foreach (model[i]) model[i] = 8'h00;
    cur_addr = 8'h00;
  endtask

  initial begin
    foreach (model[i]) model[i] = 8'h00;
    void'($urandom(32'd20240611));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(6);
    // R8: reset state, idle-high clock gives no edge
    check_outputs("R8");

    // R1 R2 R6: each implemented register maps to its output
    put_addr(8'h34); put_data(8'hA1); check_outputs("R6");
    put_addr(8'h44); put_data(8'h12); check_outputs("R6");
    put_addr(8'h54); put_data(8'h34); check_outputs("R6");
    put_addr(8'h84); put_data(8'h56); check_outputs("R6");
    put_addr(8'h94); put_data(8'h78); check_outputs("R6");
    put_addr(8'h75); put_data(8'h04); check_outputs("R6");
    put_addr(8'h44); check_outputs("R1");
    put_addr(8'h34); check_outputs("R2");

    // R1: dout follows address exactly three cycles after the pin edge
    put_addr(8'h34);
    tp_din = 8'h75; tp_en = 1'b1; wait_cyc(4);
    tp_clk = 1'b0; wait_cyc(2);
    check("R1", {24'h0, tp_dout}, {24'h0, model[8'h34]});
    wait_cyc(1);
    check("R1", {24'h0, tp_dout}, {24'h0, model[8'h75]});
    tp_clk = 1'b1; wait_cyc(4);
    cur_addr = 8'h75;

    // R4: unimplemented address reads zero and drops writes
    put_addr(8'h35); check_outputs("R4");
    put_data(8'hFF); check_outputs("R4");
    put_addr(8'h34); check_outputs("R4");

    // R3: fall with enable low, then rise with enable high
    tp_din = 8'h5A; tp_en = 1'b0; wait_cyc(4);
    tp_clk = 1'b0; wait_cyc(4);
    tp_en = 1'b1; wait_cyc(4);
    tp_clk = 1'b1; wait_cyc(4);
    check_outputs("R3");
    check("R3", {24'h0, tp_dout}, {24'h0, 8'hA1});

    // R9: repeated data phases land on one register
    put_addr(8'h54);
    put_data(8'h01); put_data(8'h02); put_data(8'h03);
    check_outputs("R9");
    check("R9", {24'h0, tp_dout}, 32'h03);

    // R7: enter and leave test mode through address 0x00
    put_addr(8'h00); put_data(8'h05); check_outputs("R7");
    check("R7", {31'h0, test_mode}, 32'h1);
    put_data(8'h00); check_outputs("R7");
    check("R7", {31'h0, test_mode}, 32'h0);

    // R5: clear zeroes everything and the address
    put_addr(8'h75);
    do_clear(); check_outputs("R5");
    put_data(8'h09); check_outputs("R5");
    check("R5", {31'h0, test_mode}, 32'h1);

    // random mix
    for (int n = 0; n < 150; n++) begin
      logic [7:0] a;
      int unsigned k = $urandom % 8;
      case (k)
        0: a = 8'h00; 1: a = 8'h34; 2: a = 8'h44; 3: a = 8'h54;
        4: a = 8'h84; 5: a = 8'h94; 6: a = 8'h75;
        default: a = 8'($urandom);
      endcase
      put_addr(a);
      put_data(8'($urandom));
      check_outputs("R2");
      if ($urandom % 25 == 0) begin
        do_clear(); check_outputs("R5");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule